// File: doc/BRIEF.md
# Per-Rank Refresh Sequencer with Power-State Tracking

This block is instantiated once for each memory rank. It keeps its own cycle count and decides when the rank needs its periodic refresh. When a refresh falls due, it withdraws the rank from the request scheduler. It then waits for any request already under way on this rank to finish. Next it closes every bank with a single precharge-all strobe and, once the row precharge time has passed, issues a refresh strobe. New row activations stay blocked until the refresh has completed. Ranks refresh independently of each other, so while one rank is busy the scheduler keeps serving the others.

Beside the refresh sequence, the block reports a coarse power state from the number of active banks. It counts how many cycles the rank spends in each power state. It raises a sticky error flag when a refresh completes after the following refresh was already due. When a refresh finishes, it sends a one-cycle wake-up request to the scheduler, unless the scheduler already has one pending.

Top module: `rank_refresh_fsm`

## Requirements
- R1: After reset the rank is available, both command strobes and `wake` are low, `late_err` is low, `act_block_until` is 0 and `pwr_state` is 0 (idle).
- R2: The internal time starts at 0 on the first clock edge after reset and counts one per cycle. The first refresh sequence begins on the edge at which the time equals T_REFI - T_RP, and `available` is low from that edge until the refresh has completed.
- R3: After the sequence begins, it stays in its drain step for as long as `req_inflight` is high. It leaves the drain step on the first edge at which `req_inflight` is low.
- R4: `pre_all` pulses for one cycle on the first edge, after draining, at which every bank's precharge-allowed time (bank i in `bank_pre_ok[i*TW +: TW]`) is no later than the current time. The same edge sets `act_block_until` to that time plus T_RP.
- R5: `refresh` pulses for one cycle on the first edge at which the time reaches `act_block_until`. The same edge sets `act_block_until` to that time plus T_RFC. The rank becomes available again on the edge at which the time reaches that completion time.
- R6: Each refresh is due T_REFI after the previous due time, and its sequence starts T_RP earlier. If that next due time is earlier than the refresh's completion time, `late_err` rises and stays high until reset.
- R7: `pwr_state` uses the codes 0 idle, 1 refresh, 2 precharge power-down, 3 active and 4 active power-down. It follows one cycle behind its cause: 1 while a refresh is in progress, otherwise 3 when `banks_active` is non-zero and 0 when it is zero.
- R8: On the edge at which the rank becomes available after a refresh, `wake` pulses for one cycle, unless `wake_pending` is high, in which case no pulse is sent.
- R9: `res_cycles[k*CNT_W +: CNT_W]` counts the clock edges at which `pwr_state` equals k, and saturates at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_inflight | input | 1 | A request on this rank is being handled |
| wake_pending | input | 1 | The scheduler already has a wake-up queued |
| bank_pre_ok | input | NUM_BANKS*TW | Per-bank earliest precharge time |
| banks_active | input | $clog2(NUM_BANKS+1) | Number of open banks |
| available | output | 1 | The rank may be scheduled |
| pre_all | output | 1 | Precharge-all strobe |
| refresh | output | 1 | Refresh strobe |
| pwr_state | output | 3 | Coarse power state code |
| act_block_until | output | TW | No activation before this time |
| late_err | output | 1 | Sticky late-refresh flag |
| wake | output | 1 | Wake-up pulse to the scheduler |
| res_cycles | output | 5*CNT_W | Per-power-state residency counters |

## Verification
The case hardest to reach from the ports is a late refresh. The next due time is fixed when the sequence starts, so the flag can only rise if completion slips past a whole refresh interval. The bench reaches it by holding `req_inflight` high for more than T_REFI cycles while the rank is draining. A second hard case is the drain and precharge wait. The bench reaches it by holding a request in flight across the refresh trigger, and by setting one bank's precharge-allowed time into the future, so that the cycles of `pre_all` and `refresh` shift by amounts the bench can predict.

// File: rtl/rank_refresh_fsm.sv
module rank_refresh_fsm #(
  parameter int NUM_BANKS = 4,
  parameter int TW        = 24,
  parameter int T_REFI    = 120,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 15,
  parameter int CNT_W     = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_inflight,
  input  logic                          wake_pending,
  input  logic [NUM_BANKS*TW-1:0]       bank_pre_ok,
  input  logic [$clog2(NUM_BANKS+1)-1:0] banks_active,
  output logic                          available,
  output logic                          pre_all,
  output logic                          refresh,
  output logic [2:0]                    pwr_state,
  output logic [TW-1:0]                 act_block_until,
  output logic                          late_err,
  output logic                          wake,
  output logic [5*CNT_W-1:0]            res_cycles
);
  localparam logic [TW-1:0] REFI  = TW'(T_REFI);
  localparam logic [TW-1:0] RP    = TW'(T_RP);
  localparam logic [TW-1:0] RFC   = TW'(T_RFC);
  localparam logic [2:0]    P_IDLE = 3'd0;
  localparam logic [2:0]    P_REF  = 3'd1;
  localparam logic [2:0]    P_ACT  = 3'd3;

  typedef enum logic [2:0] {S_IDLE, S_DRAIN, S_PRE, S_REF, S_REFW} st_t;

  st_t           st;
  logic [TW-1:0] now, ref_at, due;
  logic          banks_ready;

  always_comb begin
    banks_ready = 1'b1;
    for (int i = 0; i < NUM_BANKS; i++)
      if (bank_pre_ok[i*TW +: TW] > now) banks_ready = 1'b0;
  end

  assign available = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st              <= S_IDLE;
      now             <= '0;
      ref_at          <= REFI - RP;
      due             <= '0;
      act_block_until <= '0;
      pre_all         <= 1'b0;
      refresh         <= 1'b0;
      late_err        <= 1'b0;
      wake            <= 1'b0;
    end else begin
      now     <= now + 1'b1;
      pre_all <= 1'b0;
      refresh <= 1'b0;
      wake    <= 1'b0;
      case (st)
        S_IDLE:  if (now >= ref_at) begin
                   st  <= S_DRAIN;
                   due <= ref_at + RP;
                 end
        S_DRAIN: if (!req_inflight) st <= S_PRE;
        S_PRE:   if (banks_ready) begin
                   pre_all         <= 1'b1;
                   act_block_until <= now + RP;
                   st              <= S_REF;
                 end
        S_REF:   if (now >= act_block_until) begin
                   refresh         <= 1'b1;
                   act_block_until <= now + RFC;
                   ref_at          <= due + REFI - RP;
                   if (due + REFI < now + RFC) late_err <= 1'b1;
                   st              <= S_REFW;
                 end
        S_REFW:  if (now >= act_block_until) begin
                   st   <= S_IDLE;
                   wake <= !wake_pending;
                 end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  pwr_state <= P_IDLE;
    else if (st == S_REFW)       pwr_state <= P_REF;
    else if (banks_active != '0) pwr_state <= P_ACT;
    else                         pwr_state <= P_IDLE;
  end

  for (genvar k = 0; k < 5; k++) begin : g_res
    always_ff @(posedge clk) begin
      if (!rst_n)
        res_cycles[k*CNT_W +: CNT_W] <= '0;
      else if (pwr_state == 3'(k) && res_cycles[k*CNT_W +: CNT_W] != {CNT_W{1'b1}})
        res_cycles[k*CNT_W +: CNT_W] <= res_cycles[k*CNT_W +: CNT_W] + 1'b1;
    end
  end

  // R3
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DRAIN && req_inflight) |=> (st == S_DRAIN));

  // R4
  pre_all_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_all |-> !available);

  // R5
  refresh_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> (!refresh && !pre_all && !available));

  // R6
  late_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    late_err |=> late_err);

  // R7
  pwr_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == P_REF) |-> $past(st == S_REFW));

  // R8
  wake_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (available && $past(!wake_pending)));
endmodule

// File: tb/test_rank_refresh_fsm.sv
module test_rank_refresh_fsm;
  localparam int NB = 4, TW = 24, REFI = 120, RP = 3, RFC = 15, CW = 16;

  logic clk = 0, rst_n = 0, req_inflight = 0, wake_pending = 0;
  logic [NB*TW-1:0] bank_pre_ok = '0;
  logic [$clog2(NB+1)-1:0] banks_active = '0;
  logic available, pre_all, refresh, late_err, wake;
  logic [2:0] pwr_state;
  logic [TW-1:0] act_block_until;
  logic [5*CW-1:0] res_cycles;

  int cyc = 0, checks = 0, fails = 0, n_pre = 0;

  rank_refresh_fsm #(.NUM_BANKS(NB), .TW(TW), .T_REFI(REFI), .T_RP(RP),
                     .T_RFC(RFC), .CNT_W(CW)) i_rank_refresh_fsm (
    .clk(clk), .rst_n(rst_n), .req_inflight(req_inflight),
    .wake_pending(wake_pending), .bank_pre_ok(bank_pre_ok),
    .banks_active(banks_active), .available(available), .pre_all(pre_all),
    .refresh(refresh), .pwr_state(pwr_state),
    .act_block_until(act_block_until), .late_err(late_err), .wake(wake),
    .res_cycles(res_cycles));

  always #10 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;
  always @(negedge clk) if (pre_all) n_pre <= n_pre + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  function automatic logic pick(input int which);
    case (which)
      0: return available;
      1: return pre_all;
      default: return refresh;
    endcase
  endfunction

  task automatic wait_for(input string req, input int which, input logic lvl, output int at);
    int n = 0;
    while (pick(which) !== lvl && n < 2000) begin
      @(negedge clk);
      n++;
    end
    at = cyc;
    if (n >= 2000) begin
      checks++; fails++;
      $display("FAIL %s timeout waiting for signal %0d", req, which);
    end
  endtask

  task automatic t_reset;
    check("R1 available", available, 1);
    check("R1 pre_all", pre_all, 0);
    check("R1 refresh", refresh, 0);
    check("R1 wake", wake, 0);
    check("R1 late_err", late_err, 0);
    check("R1 act_block", act_block_until, 0);
    check("R1 pwr_state", pwr_state, 0);
  endtask

  task automatic t_power;
    banks_active = 2;
    @(negedge clk);
    check("R7 pwr active", pwr_state, 3);
    wait_cyc(5);
    banks_active = 0;
    @(negedge clk);
    check("R7 pwr idle", pwr_state, 0);
    check("R9 active residency", res_cycles[3*CW +: CW], 5);
    check("R9 idle residency", res_cycles[0 +: CW], 1);
  endtask

  task automatic t_first_refresh;
    int at;
    wait_for("R2", 0, 1'b0, at);
    check("R2 first refresh start", at, REFI - RP + 1);
    wait_for("R4", 1, 1'b1, at);
    check("R4 pre_all cycle", at, 120);
    check("R4 act_block after pre_all", act_block_until, 122);
    check("R2 unavailable in precharge", available, 0);
    wait_for("R5", 2, 1'b1, at);
    check("R5 refresh cycle", at, 123);
    check("R5 act_block after refresh", act_block_until, 137);
    @(negedge clk);
    check("R7 pwr refresh", pwr_state, 1);
    wait_for("R5", 0, 1'b1, at);
    check("R5 available again", at, 138);
    check("R8 wake pulse", wake, 1);
    @(negedge clk);
    check("R8 wake one cycle", wake, 0);
    @(negedge clk);
    check("R9 refresh residency", res_cycles[1*CW +: CW], RFC);
    check("R6 no late", late_err, 0);
  endtask

  task automatic t_drain;
    int at;
    req_inflight = 1;
    wake_pending = 1;
    bank_pre_ok[2*TW +: TW] = 24'd260;
    wait_for("R6", 0, 1'b0, at);
    check("R6 second start one period later", at, 238);
    wait_cyc(250);
    check("R3 still draining", available, 0);
    check("R3 no precharge while in flight", n_pre, 1);
    req_inflight = 0;
    wait_for("R4", 1, 1'b1, at);
    check("R4 pre_all waits for bank", at, 261);
    check("R4 act_block bank wait", act_block_until, 263);
    wait_for("R5", 2, 1'b1, at);
    check("R5 refresh after drain", at, 264);
    wait_for("R5", 0, 1'b1, at);
    check("R5 done after drain", at, 279);
    check("R8 wake suppressed", wake, 0);
    @(negedge clk);
    check("R8 wake still suppressed", wake, 0);
    check("R6 no late after drain", late_err, 0);
  endtask

  task automatic t_late;
    int at;
    wake_pending = 0;
    bank_pre_ok = '0;
    req_inflight = 1;
    wait_for("R6", 0, 1'b0, at);
    check("R6 third start", at, 358);
    wait_cyc(480);
    check("R3 long drain", available, 0);
    req_inflight = 0;
    wait_for("R4", 1, 1'b1, at);
    check("R4 pre_all after long drain", at, 482);
    wait_for("R5", 2, 1'b1, at);
    check("R5 refresh after long drain", at, 485);
    @(negedge clk);
    check("R6 late flag", late_err, 1);
    wait_for("R5", 0, 1'b1, at);
    check("R5 late done", at, 500);
    check("R8 wake after late", wake, 1);
    wait_cyc(520);
    check("R6 late sticky", late_err, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1;
    t_power();
    t_first_refresh();
    t_drain();
    t_late();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(100000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule